// File: doc/BRIEF.md
# Byte Logic and Compare Unit with Condition Flags

This block is the bitwise and compare part of an 8-bit accumulator datapath. Each operation combines the accumulator with one operand and gives the new accumulator value and a packed flag byte holding zero, subtract, half-carry and carry. The four operations are AND, XOR, OR and compare. Compare works out accumulator minus operand and changes only the flags.

The operand can be any of the seven working registers. It can also be an immediate byte read at the program counter, or a memory byte at the address formed by the H:L register pair. A register operand is finished one cycle after the start strobe. An immediate or memory operand first raises a one-cycle read request in the start cycle. The unit takes the returned byte in the following cycle and finishes one cycle after that. The results are registered and hold until the next operation completes. A done pulse marks each completion.

Top module: `bytelogic_alu`

## Requirements
- R1: After reset, accOut and flagsOut are zero, and done and rdReq are low.
- R2: AND (opSel 0) sets accOut to A & operand. It sets Z when that result is zero, sets H, and clears N and C.
- R3: XOR (opSel 1) and OR (opSel 2) set accOut to the combined value. They set Z when it is zero and clear N, H and C.
- R4: Compare (opSel 3) leaves accOut equal to the A value used. It sets N, sets Z when A equals the operand, and sets C when the operand is greater than A.
- R5: For compare, H is set exactly when the low nibble of the operand is greater than the low nibble of A.
- R6: srcSel codes 0 to 6 select registers A, B, C, D, E, H and L. With these codes no read is requested, and done rises one cycle after start.
- R7: srcSel code 7 selects an immediate byte. In the start cycle rdReq is high and rdAddr equals pcIn. rdData is taken in the next cycle, and done rises two cycles after start.
- R8: srcSel code 8 selects memory. In the start cycle rdReq is high and rdAddr equals {regH, regL}. The timing is the same as in R7.
- R9: The flag byte carries Z in bit 7, N in bit 6, H in bit 5 and C in bit 4, and bits 3 to 0 always read zero.
- R10: A start raised while a fetch-sourced operation waits for its byte is ignored. It produces no extra done, and the pending result is unchanged.
- R11: Between completions, accOut and flagsOut hold their values and done stays low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an operation |
| opSel | input | 2 | 0 AND, 1 XOR, 2 OR, 3 compare |
| srcSel | input | 4 | Operand source code |
| regA | input | DATA_W | Accumulator value |
| regB | input | DATA_W | Register B |
| regC | input | DATA_W | Register C |
| regD | input | DATA_W | Register D |
| regE | input | DATA_W | Register E |
| regH | input | DATA_W | Register H (high address byte) |
| regL | input | DATA_W | Register L (low address byte) |
| pcIn | input | 2*DATA_W | Address of the immediate byte |
| rdReq | output | 1 | One-byte read request |
| rdAddr | output | 2*DATA_W | Read address |
| rdData | input | DATA_W | Byte returned the cycle after rdReq |
| accOut | output | DATA_W | Updated accumulator |
| flagsOut | output | 8 | Packed flags Z N H C, then four zero bits |
| done | output | 1 | Completion pulse |

## Verification
The bench builds the unit with the default DATA_W of 8. With that width the half-carry boundary falls between bits 3 and 4, and read addresses are 16 bits wide. This lets hand-worked vectors reach borrow out of the low nibble, full-width borrow, equality and zero results from every operand code. The fetch tests change regA during the wait cycle, so a result taken from the live register instead of the captured one shows up at the outputs.

// File: rtl/bytelogic_pkg.sv
package bytelogic_pkg;

  localparam int SRC_W = 4;

  typedef enum logic [1:0] {
    OP_AND = 2'd0,
    OP_XOR = 2'd1,
    OP_OR  = 2'd2,
    OP_CMP = 2'd3
  } aluOp_t;

  localparam logic [SRC_W-1:0] SRC_A   = 4'd0;
  localparam logic [SRC_W-1:0] SRC_B   = 4'd1;
  localparam logic [SRC_W-1:0] SRC_C   = 4'd2;
  localparam logic [SRC_W-1:0] SRC_D   = 4'd3;
  localparam logic [SRC_W-1:0] SRC_E   = 4'd4;
  localparam logic [SRC_W-1:0] SRC_H   = 4'd5;
  localparam logic [SRC_W-1:0] SRC_L   = 4'd6;
  localparam logic [SRC_W-1:0] SRC_IMM = 4'd7;
  localparam logic [SRC_W-1:0] SRC_MEM = 4'd8;

  localparam int FLAG_Z = 7;
  localparam int FLAG_N = 6;
  localparam int FLAG_H = 5;
  localparam int FLAG_C = 4;

  typedef struct packed {
    logic latch;       // capture op and accumulator for a fetch
    logic commit;      // register a new result this cycle
    logic useFetched;  // compute from captured values and rdData
  } ctrlStrobes_t;

endpackage

// File: rtl/bytelogic_ctrl.sv
module bytelogic_ctrl
  import bytelogic_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [SRC_W-1:0] srcSel,
  output ctrlStrobes_t     strobes,
  output logic             rdReq
);

  typedef enum logic {ST_IDLE, ST_FETCH} ctrlState_t;

  ctrlState_t state, nextState;
  logic needsFetch;

  assign needsFetch = (srcSel == SRC_IMM) || (srcSel == SRC_MEM);

  always_comb begin
    strobes   = '0;
    rdReq     = 1'b0;
    nextState = state;
    case (state)
      ST_IDLE: begin
        if (start) begin
          if (needsFetch) begin
            strobes.latch = 1'b1;
            rdReq         = 1'b1;
            nextState     = ST_FETCH;
          end else begin
            strobes.commit = 1'b1;
          end
        end
      end
      ST_FETCH: begin
        strobes.commit     = 1'b1;
        strobes.useFetched = 1'b1;
        nextState          = ST_IDLE;
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  AST_FETCH_COMMITS: assert property (@(posedge clk) disable iff (!rstN)
    rdReq |=> (strobes.commit && strobes.useFetched)); // R7
  AST_BUSY_NO_LATCH: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_FETCH) |-> (!strobes.latch && !rdReq)); // R10

endmodule

// File: rtl/bytelogic_dp.sv
module bytelogic_dp
  import bytelogic_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  ctrlStrobes_t        strobes,
  input  logic [1:0]          opSel,
  input  logic [SRC_W-1:0]    srcSel,
  input  logic [DATA_W-1:0]   regA,
  input  logic [DATA_W-1:0]   regB,
  input  logic [DATA_W-1:0]   regC,
  input  logic [DATA_W-1:0]   regD,
  input  logic [DATA_W-1:0]   regE,
  input  logic [DATA_W-1:0]   regH,
  input  logic [DATA_W-1:0]   regL,
  input  logic [2*DATA_W-1:0] pcIn,
  input  logic [DATA_W-1:0]   rdData,
  output logic [2*DATA_W-1:0] rdAddr,
  output logic [DATA_W-1:0]   accOut,
  output logic [7:0]          flagsOut,
  output logic                done
);

  localparam int HALF_W = DATA_W / 2;

  aluOp_t            opQ, curOp;
  logic [DATA_W-1:0] accQ, curA, curB, liveOperand;
  logic [DATA_W-1:0] nextAcc;
  logic [7:0]        nextFlags;
  logic [DATA_W:0]   diff;
  logic              halfBorrow;

  always_comb begin
    case (srcSel)
      SRC_B:   liveOperand = regB;
      SRC_C:   liveOperand = regC;
      SRC_D:   liveOperand = regD;
      SRC_E:   liveOperand = regE;
      SRC_H:   liveOperand = regH;
      SRC_L:   liveOperand = regL;
      default: liveOperand = regA;
    endcase
  end

  assign rdAddr = (srcSel == SRC_MEM) ? {regH, regL} : pcIn;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      opQ  <= OP_AND;
      accQ <= '0;
    end else if (strobes.latch) begin
      opQ  <= aluOp_t'(opSel);
      accQ <= regA;
    end
  end

  assign curOp = strobes.useFetched ? opQ  : aluOp_t'(opSel);
  assign curA  = strobes.useFetched ? accQ : regA;
  assign curB  = strobes.useFetched ? rdData : liveOperand;

  assign diff       = {1'b0, curA} - {1'b0, curB};
  assign halfBorrow = curB[HALF_W-1:0] > curA[HALF_W-1:0];

  always_comb begin
    nextFlags = '0;
    case (curOp)
      OP_AND: begin
        nextAcc           = curA & curB;
        nextFlags[FLAG_H] = 1'b1;
      end
      OP_XOR: nextAcc = curA ^ curB;
      OP_OR:  nextAcc = curA | curB;
      default: begin
        nextAcc           = curA;
        nextFlags[FLAG_N] = 1'b1;
        nextFlags[FLAG_H] = halfBorrow;
        nextFlags[FLAG_C] = diff[DATA_W];
      end
    endcase
    if (curOp == OP_CMP) nextFlags[FLAG_Z] = (diff[DATA_W-1:0] == '0);
    else                 nextFlags[FLAG_Z] = (nextAcc == '0);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      accOut   <= '0;
      flagsOut <= '0;
      done     <= 1'b0;
    end else begin
      done <= strobes.commit;
      if (strobes.commit) begin
        accOut   <= nextAcc;
        flagsOut <= nextFlags;
      end
    end
  end

  AST_AND_FLAGS: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.commit && curOp == OP_AND) |=>
      (flagsOut[FLAG_H] && !flagsOut[FLAG_N] && !flagsOut[FLAG_C])); // R2
  AST_LOGIC_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.commit && curOp != OP_CMP) |=> (flagsOut[FLAG_Z] == (accOut == '0))); // R2
  AST_XOR_OR_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.commit && (curOp == OP_XOR || curOp == OP_OR)) |=>
      (flagsOut[6:4] == 3'b000)); // R3
  AST_CMP_KEEPS_A: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.commit && curOp == OP_CMP) |=>
      (flagsOut[FLAG_N] && accOut == $past(curA))); // R4
  AST_LOW_BITS_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    flagsOut[3:0] == 4'h0); // R9
  AST_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.commit |=> ($stable(accOut) && $stable(flagsOut) && !done)); // R11

endmodule

// File: rtl/bytelogic_alu.sv
module bytelogic_alu
  import bytelogic_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                start,
  input  logic [1:0]          opSel,
  input  logic [3:0]          srcSel,
  input  logic [DATA_W-1:0]   regA,
  input  logic [DATA_W-1:0]   regB,
  input  logic [DATA_W-1:0]   regC,
  input  logic [DATA_W-1:0]   regD,
  input  logic [DATA_W-1:0]   regE,
  input  logic [DATA_W-1:0]   regH,
  input  logic [DATA_W-1:0]   regL,
  input  logic [2*DATA_W-1:0] pcIn,
  output logic                rdReq,
  output logic [2*DATA_W-1:0] rdAddr,
  input  logic [DATA_W-1:0]   rdData,
  output logic [DATA_W-1:0]   accOut,
  output logic [7:0]          flagsOut,
  output logic                done
);

  ctrlStrobes_t strobes;

  bytelogic_ctrl uCtrl (
    .clk     (clk),
    .rstN    (rstN),
    .start   (start),
    .srcSel  (srcSel),
    .strobes (strobes),
    .rdReq   (rdReq)
  );

  bytelogic_dp #(.DATA_W(DATA_W)) uDp (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .opSel    (opSel),
    .srcSel   (srcSel),
    .regA     (regA),
    .regB     (regB),
    .regC     (regC),
    .regD     (regD),
    .regE     (regE),
    .regH     (regH),
    .regL     (regL),
    .pcIn     (pcIn),
    .rdData   (rdData),
    .rdAddr   (rdAddr),
    .accOut   (accOut),
    .flagsOut (flagsOut),
    .done     (done)
  );

  AST_REG_SRC_DONE: assert property (@(posedge clk) disable iff (!rstN)
    (start && !rdReq && srcSel < 4'd7 && !$past(rdReq)) |=> done); // R6

endmodule

// File: tb/bytelogic_alu_test.sv
`timescale 1ns/1ps
module bytelogic_alu_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [1:0]  opSel = 2'd0;
  logic [3:0]  srcSel = 4'd0;
  logic [7:0]  regA = 8'h0, regB = 8'h0, regC = 8'h0, regD = 8'h0;
  logic [7:0]  regE = 8'h0, regH = 8'h0, regL = 8'h0;
  logic [15:0] pcIn = 16'h0;
  logic        rdReq;
  logic [15:0] rdAddr;
  logic [7:0]  rdData = 8'h0;
  logic [7:0]  accOut;
  logic [7:0]  flagsOut;
  logic        done;

  int checks = 0;
  int fails = 0;

  always #2.5 clk = ~clk;

  bytelogic_alu uut (
    .clk(clk), .rstN(rstN), .start(start), .opSel(opSel), .srcSel(srcSel),
    .regA(regA), .regB(regB), .regC(regC), .regD(regD), .regE(regE),
    .regH(regH), .regL(regL), .pcIn(pcIn), .rdReq(rdReq), .rdAddr(rdAddr),
    .rdData(rdData), .accOut(accOut), .flagsOut(flagsOut), .done(done)
  );

  // {op, src, A, operand, expected acc, expected flags}
  localparam logic [37:0] VECS [16] = '{
    {2'd0, 4'd1, 8'hF0, 8'h3C, 8'h30, 8'h20},
    {2'd0, 4'd2, 8'h0F, 8'hF0, 8'h00, 8'hA0},
    {2'd1, 4'd3, 8'hAA, 8'hAA, 8'h00, 8'h80},
    {2'd1, 4'd4, 8'hA5, 8'h0F, 8'hAA, 8'h00},
    {2'd2, 4'd5, 8'h00, 8'h00, 8'h00, 8'h80},
    {2'd2, 4'd6, 8'h12, 8'h40, 8'h52, 8'h00},
    {2'd3, 4'd1, 8'h42, 8'h42, 8'h42, 8'hC0},
    {2'd3, 4'd2, 8'h10, 8'h20, 8'h10, 8'h50},
    {2'd3, 4'd3, 8'h31, 8'h0F, 8'h31, 8'h60},
    {2'd3, 4'd0, 8'h7E, 8'h7E, 8'h7E, 8'hC0},
    {2'd0, 4'd0, 8'h81, 8'h81, 8'h81, 8'h20},
    {2'd3, 4'd7, 8'h05, 8'hFA, 8'h05, 8'h70},
    {2'd2, 4'd8, 8'h01, 8'h80, 8'h81, 8'h00},
    {2'd0, 4'd7, 8'hFF, 8'h00, 8'h00, 8'hA0},
    {2'd1, 4'd8, 8'h3C, 8'hC3, 8'hFF, 8'h00},
    {2'd3, 4'd8, 8'h00, 8'h01, 8'h00, 8'h70}
  };

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic loadRegs(input logic [3:0] src, input logic [7:0] a, input logic [7:0] b);
    regA = a; regB = 8'h11; regC = 8'h22; regD = 8'h33;
    regE = 8'h44; regH = 8'h12; regL = 8'h34; pcIn = 16'hBEEF;
    case (src)
      4'd1: regB = b;
      4'd2: regC = b;
      4'd3: regD = b;
      4'd4: regE = b;
      4'd5: regH = b;
      4'd6: regL = b;
      default: ;
    endcase
  endtask

  task automatic runVec(input logic [37:0] v);
    logic [1:0] op;
    logic [3:0] src;
    logic [7:0] a, b, ea, ef;
    string tag;
    logic fetch;
    {op, src, a, b, ea, ef} = v;
    fetch = (src == 4'd7) || (src == 4'd8);
    tag = (op == 2'd0) ? "R2" : (op == 2'd3) ? "R4/R5" : "R3";
    @(negedge clk);
    loadRegs(src, a, b);
    opSel = op; srcSel = src; start = 1'b1; rdData = 8'h00;
    #1;
    if (fetch) begin
      check("R7 rdReq", {15'h0, rdReq}, 16'h1);
      check("R8 rdAddr", rdAddr, (src == 4'd8) ? 16'h1234 : 16'hBEEF);
    end else begin
      check("R6 no read", {15'h0, rdReq}, 16'h0);
    end
    @(negedge clk);
    start = 1'b0;
    if (fetch) begin
      check("R7 wait", {15'h0, done}, 16'h0);
      rdData = b;
      regA = ~a;
      @(negedge clk);
    end
    check({tag, " done R6"}, {15'h0, done}, 16'h1);
    check({tag, " acc"}, {8'h0, accOut}, {8'h0, ea});
    check({tag, " flags"}, {8'h0, flagsOut}, {8'h0, ef});
    check("R9 low bits", {12'h0, flagsOut[3:0]}, 16'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 acc", {8'h0, accOut}, 16'h0);
    check("R1 flags", {8'h0, flagsOut}, 16'h0);
    check("R1 done", {15'h0, done}, 16'h0);
    check("R1 rdReq", {15'h0, rdReq}, 16'h0);
    rstN = 1'b1;

    for (int i = 0; i < 16; i++) runVec(VECS[i]);

    // R10: start while a fetch is pending
    @(negedge clk);
    loadRegs(4'd7, 8'hF0, 8'h00);
    opSel = 2'd0; srcSel = 4'd7; start = 1'b1;
    @(negedge clk);
    rdData = 8'h3C; opSel = 2'd1; srcSel = 4'd1; regB = 8'h0F; regA = 8'h00;
    @(negedge clk);
    start = 1'b0;
    check("R10 done", {15'h0, done}, 16'h1);
    check("R10 acc", {8'h0, accOut}, 16'h0030);
    check("R10 flags", {8'h0, flagsOut}, 16'h0020);
    @(negedge clk);
    check("R10 no extra done", {15'h0, done}, 16'h0);
    check("R10 acc kept", {8'h0, accOut}, 16'h0030);

    // R11: outputs hold while idle
    regA = 8'h99; regB = 8'h66; opSel = 2'd2; srcSel = 4'd1;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check("R11 acc hold", {8'h0, accOut}, 16'h0030);
      check("R11 flags hold", {8'h0, flagsOut}, 16'h0020);
      check("R11 done low", {15'h0, done}, 16'h0);
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule